// File: doc/BRIEF.md
# Control-Flow Integrity Monitor

The block sits beside a processor core and watches its retire stream. A table of basic-block descriptors, computed before the program runs, tells it what each block must look like. A descriptor holds the block's first address, its exact instruction count, the two legal successor addresses and a 32-bit fingerprint of its instruction words. While a block retires, the monitor counts its instructions and folds each instruction word into a running fingerprint. When the block ends with a control transfer, it checks the count, the destination and the fingerprint together.

Calls and returns are tracked on a private stack of return addresses. The core has no way to read or write that stack. The first violation raises a sticky alarm with a cause code, and the monitor then ignores the rest of the stream until reset. The descriptor table is filled through a write port before the program starts.

Top module: `cf_monitor`

## Requirements
- R1: After reset `alarm` is 0, `alarm_cause` is 0, the descriptor table holds no valid entry and the return stack is empty.
- R2: The first retire after reset, and the first retire after any control transfer, starts a block. If no valid descriptor has a start address equal to its pc, the alarm is raised with cause 5.
- R3: Transfer kinds are coded as 0 sequential, 1 conditional branch, 2 jump, 3 call and 4 return. At the end of a block a conditional branch must target either the taken or the fall-through address of the descriptor. A jump or a call must target the taken address. Any other destination raises cause 1. A return is not checked against the descriptor.
- R4: Count check: the first instruction of a block counts as 1. A transfer retired at a count other than the descriptor's count raises cause 2. A sequential instruction that brings the count up to the descriptor's count also raises cause 2.
- R5: A call pushes its own pc plus 4 onto a 16-entry return stack. A return pops the stack, and its target must equal the popped value; otherwise the alarm is raised with cause 3.
- R6: A call made while 16 entries are held, or a return made while the stack is empty, raises cause 3.
- R7: The fingerprint of a block starts at 0. For each retired word w it becomes (h rotated left by 5) XOR w. At every transfer the fingerprint must equal the descriptor value; otherwise the alarm is raised with cause 4.
- R8: When several violations occur on the same retire, the reported cause follows the priority missing descriptor (5) > stack (3) > count (2) > target (1) > fingerprint (4).
- R9: The alarm and its cause are sticky until reset. Retires that arrive after the alarm change neither of them.
- R10: The alarm rises on the clock edge that takes in the offending retire. A stream that follows its descriptors never raises it, and cycles with `ret_valid` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meta_we | input | 1 | Write one descriptor |
| meta_idx | input | IDX_W | Descriptor slot |
| meta_start | input | AW | Block start address |
| meta_count | input | CW | Exact instruction count |
| meta_taken | input | AW | Taken / unconditional target |
| meta_fall | input | AW | Fall-through target |
| meta_hash | input | 32 | Reference fingerprint |
| ret_valid | input | 1 | A retire is presented |
| ret_pc | input | AW | Retired pc |
| ret_insn | input | 32 | Retired instruction word |
| ret_kind | input | 3 | Transfer kind (0..4) |
| ret_target | input | AW | Destination of a transfer |
| alarm | output | 1 | Sticky violation flag |
| alarm_cause | output | 3 | Cause of the first violation |

## Verification
The hardest state to reach from the ports is a full return stack met by one more call. Only then can the overflow check fire. The stimulus loads a descriptor whose one-instruction block calls its own start address. Sixteen calls then fill the stack legally, and the bench confirms the alarm is still quiet before issuing the seventeenth. For the instruction-count watchdog, the bench sweeps every block length from 1 to 4 against every transfer position from 1 to 5. This covers early transfers, exact transfers and runs that pass the expected count.

// File: rtl/cf_monitor.sv
module cf_monitor #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int NBLK = 8,
  parameter int SS_DEPTH = 16,
  localparam int IDX_W = $clog2(NBLK),
  localparam int SP_W = $clog2(SS_DEPTH + 1),
  localparam int SI_W = $clog2(SS_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meta_we,
  input  logic [IDX_W-1:0] meta_idx,
  input  logic [AW-1:0]    meta_start,
  input  logic [CW-1:0]    meta_count,
  input  logic [AW-1:0]    meta_taken,
  input  logic [AW-1:0]    meta_fall,
  input  logic [31:0]      meta_hash,
  input  logic             ret_valid,
  input  logic [AW-1:0]    ret_pc,
  input  logic [31:0]      ret_insn,
  input  logic [2:0]       ret_kind,
  input  logic [AW-1:0]    ret_target,
  output logic             alarm,
  output logic [2:0]       alarm_cause
);
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(SS_DEPTH);

  logic [AW-1:0] t_start [NBLK];
  logic [AW-1:0] t_taken [NBLK];
  logic [AW-1:0] t_fall  [NBLK];
  logic [CW-1:0] t_cnt   [NBLK];
  logic [31:0]   t_hash  [NBLK];
  logic [NBLK-1:0] t_vld;

  logic [AW-1:0] ss [SS_DEPTH];
  logic [SP_W-1:0] sp;

  logic in_blk;
  logic [IDX_W-1:0] cur_idx;
  logic [CW-1:0] cnt;
  logic [31:0] hsh;

  logic hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NBLK; i++)
      if (t_vld[i] && t_start[i] == ret_pc) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  logic [IDX_W-1:0] idx;
  logic [CW-1:0] cnt_n;
  logic [31:0] h_base, h_n;
  logic xfer, is_call, is_ret;
  logic [SP_W-1:0] sp_m1;
  logic e_miss, e_stk, e_cnt, e_tgt, e_hash;
  logic [2:0] cause_n;

  assign idx     = in_blk ? cur_idx : hit_idx;
  assign cnt_n   = (in_blk ? cnt : '0) + CW'(1);
  assign h_base  = in_blk ? hsh : 32'h0;
  assign h_n     = {h_base[26:0], h_base[31:27]} ^ ret_insn;
  assign xfer    = ret_kind != 3'd0;
  assign is_call = ret_kind == 3'd3;
  assign is_ret  = ret_kind == 3'd4;
  assign sp_m1   = sp - SP_W'(1);

  assign e_miss = !in_blk && !hit;
  assign e_cnt  = xfer ? (cnt_n != t_cnt[idx]) : (cnt_n >= t_cnt[idx]);
  assign e_hash = xfer && (h_n != t_hash[idx]);
  assign e_stk  = (is_call && sp == SP_FULL) ||
                  (is_ret && (sp == '0 || ss[sp_m1[SI_W-1:0]] != ret_target));

  always_comb begin
    case (ret_kind)
      3'd1:      e_tgt = ret_target != t_taken[idx] && ret_target != t_fall[idx];
      3'd2, 3'd3: e_tgt = ret_target != t_taken[idx];
      default:   e_tgt = 1'b0;
    endcase
  end

  always_comb begin
    if (e_miss)      cause_n = 3'd5;
    else if (e_stk)  cause_n = 3'd3;
    else if (e_cnt)  cause_n = 3'd2;
    else if (e_tgt)  cause_n = 3'd1;
    else if (e_hash) cause_n = 3'd4;
    else             cause_n = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (meta_we) begin
      t_start[meta_idx] <= meta_start;
      t_taken[meta_idx] <= meta_taken;
      t_fall[meta_idx]  <= meta_fall;
      t_cnt[meta_idx]   <= meta_count;
      t_hash[meta_idx]  <= meta_hash;
    end
    if (ret_valid && !alarm && cause_n == 3'd0 && is_call)
      ss[sp[SI_W-1:0]] <= ret_pc + AW'(4);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_vld <= '0;
    end else if (meta_we) begin
      t_vld[meta_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm <= 1'b0;
      alarm_cause <= 3'd0;
      in_blk <= 1'b0;
      cur_idx <= '0;
      cnt <= '0;
      hsh <= '0;
      sp <= '0;
    end else if (ret_valid && !alarm) begin
      if (cause_n != 3'd0) begin
        alarm <= 1'b1;
        alarm_cause <= cause_n;
      end else begin
        in_blk <= !xfer;
        cur_idx <= idx;
        cnt <= cnt_n;
        hsh <= h_n;
        if (is_call) sp <= sp + SP_W'(1);
        else if (is_ret) sp <= sp_m1;
      end
    end
  end

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) alarm |=> alarm); // R9
  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) alarm |=> $stable(alarm_cause)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!ret_valid && !alarm) |=> !alarm); // R10
  AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sp <= SP_FULL); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (in_blk && !alarm) |-> cnt < t_cnt[cur_idx]); // R4
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) alarm |-> (alarm_cause != 3'd0 && alarm_cause <= 3'd5)); // R8
endmodule

// File: tb/cf_monitor_tb.sv
`timescale 1ns/1ps
module cf_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meta_we = 1'b0;
  logic [2:0] meta_idx = '0;
  logic [31:0] meta_start = '0, meta_taken = '0, meta_fall = '0, meta_hash = '0;
  logic [7:0] meta_count = '0;
  logic ret_valid = 1'b0;
  logic [31:0] ret_pc = '0, ret_insn = '0, ret_target = '0;
  logic [2:0] ret_kind = '0;
  logic alarm;
  logic [2:0] alarm_cause;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cf_monitor u_dut (.clk(clk), .rst_n(rst_n), .meta_we(meta_we), .meta_idx(meta_idx),
    .meta_start(meta_start), .meta_count(meta_count), .meta_taken(meta_taken),
    .meta_fall(meta_fall), .meta_hash(meta_hash), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_insn(ret_insn), .ret_kind(ret_kind), .ret_target(ret_target),
    .alarm(alarm), .alarm_cause(alarm_cause));

  function automatic logic [31:0] bs(int k); return 32'h1000 + 32'(k % 8) * 32'h100; endfunction
  function automatic int bc(int k); return (k % 4) + 1; endfunction
  function automatic logic [31:0] bw(int k, int i); return bs(k) ^ (32'(i) * 32'h9E37) ^ 32'h13; endfunction
  function automatic logic [31:0] step(logic [31:0] h, logic [31:0] w); return {h[26:0], h[31:27]} ^ w; endfunction
  function automatic logic [31:0] bh(int k);
    logic [31:0] h = 32'h0;
    for (int i = 0; i < bc(k); i++) h = step(h, bw(k, i));
    return h;
  endfunction

  task automatic chk(string tag, logic [2:0] exp);
    checks++;
    if (alarm !== (exp != 3'd0) || alarm_cause !== exp) begin
      fails++;
      $display("FAIL %s: alarm=%0b cause=%0d expected cause=%0d", tag, alarm, alarm_cause, exp);
    end
  endtask

  task automatic wr(int i, logic [31:0] s, int c, logic [31:0] t, logic [31:0] f, logic [31:0] h);
    @(negedge clk);
    meta_we = 1'b1; meta_idx = 3'(i); meta_start = s; meta_count = 8'(c);
    meta_taken = t; meta_fall = f; meta_hash = h;
    @(negedge clk);
    meta_we = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 8; k++) wr(k, bs(k), bc(k), bs(k + 1), bs(k + 2), bh(k));
  endtask

  task automatic ret1(logic [31:0] pc, logic [31:0] w, logic [2:0] kd, logic [31:0] tg);
    @(negedge clk);
    ret_valid = 1'b1; ret_pc = pc; ret_insn = w; ret_kind = kd; ret_target = tg;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic blk(int k, int p, logic [2:0] kd, logic [31:0] tg, logic [31:0] flip);
    for (int i = 0; i < p; i++)
      ret1(bs(k) + 32'(4 * i), bw(k, i) ^ (i == 0 ? flip : 32'h0),
           (i == p - 1) ? kd : 3'd0, tg);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", 3'd0);

    restart();
    blk(0, 1, 3'd1, bs(2), 0);
    blk(2, 3, 3'd2, bs(3), 0);
    repeat (3) @(negedge clk);
    blk(3, 4, 3'd1, bs(4), 0);
    chk("R10 legal chain with idle gaps", 3'd0);

    for (int n = 1; n <= 4; n++)
      for (int p = 1; p <= 5; p++) begin
        restart();
        blk(n - 1, p, 3'd2, bs(n), 0);
        chk($sformatf("R4 count n=%0d p=%0d", n, p), (p == n) ? 3'd0 : 3'd2);
      end

    for (int c = 0; c < 6; c++) begin
      logic [31:0] tg;
      logic [2:0] kd, ex;
      kd = (c < 3) ? 3'd1 : 3'd2;
      tg = (c % 3 == 0) ? bs(3) : (c % 3 == 1) ? bs(4) : 32'hDEAD0;
      ex = (c == 0 || c == 1 || c == 3) ? 3'd0 : 3'd1;
      restart();
      blk(2, 3, kd, tg, 0);
      chk($sformatf("R3 target kind=%0d case=%0d", kd, c), ex);
    end

    restart();
    blk(1, 2, 3'd1, bs(2), 32'h4);
    chk("R7 corrupted word", 3'd4);
    blk(0, 1, 3'd2, bs(1), 0);
    chk("R9 alarm holds after later retires", 3'd4);

    restart();
    ret1(32'h7777_0000, 32'h0, 3'd0, 0);
    chk("R2 missing descriptor", 3'd5);

    restart();
    blk(0, 1, 3'd3, bs(1), 0);
    blk(1, 2, 3'd4, bs(0) + 4, 0);
    chk("R5 matched return", 3'd0);

    restart();
    blk(0, 1, 3'd3, bs(1), 0);
    blk(1, 2, 3'd4, bs(0) + 8, 0);
    chk("R5 mismatched return", 3'd3);

    restart();
    blk(0, 1, 3'd4, bs(1), 0);
    chk("R6 underflow", 3'd3);

    restart();
    wr(7, 32'h8000, 1, 32'h8000, 32'h8000, step(32'h0, 32'hCAFE));
    for (int i = 0; i < 16; i++) ret1(32'h8000, 32'hCAFE, 3'd3, 32'h8000);
    chk("R6 sixteen calls accepted", 3'd0);
    ret1(32'h8000, 32'hCAFE, 3'd3, 32'h8000);
    chk("R6 overflow", 3'd3);

    restart();
    blk(2, 2, 3'd2, 32'hBAD0, 0);
    chk("R8 count over target", 3'd2);
    restart();
    blk(1, 1, 3'd4, 32'h0, 0);
    chk("R8 stack over count", 3'd3);
    restart();
    blk(2, 3, 3'd2, 32'hBAD0, 32'h1);
    chk("R8 target over fingerprint", 3'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule